// File: doc/BRIEF.md
# Deferred Register Update Queue

This block holds a small ring of pending writes to architectural state. A write is posted with a destination index, a delay in ticks, a value, and a mode: either one bit set or cleared, or a whole word written at 32 or 64 bits. Each `tick` pulse starts a drain pass. The pass visits the live entries one per cycle, starting at the oldest. Every live entry it visits has its remaining delay reduced by one. An entry whose delay runs out is issued on the write port in that pass. The target register file applies it as `dest = (dest & ~wr_mask) | (wr_data & wr_mask)`.

An entry may run out of delay while it is not the oldest. In that case it is issued once and then kept as a finished slot. Slots are reclaimed only from the head, so it is freed when every older entry has gone. The ring keeps an input pointer, an output pointer and a live count. A pointer/count disagreement found at a tick locks the block into a fault state.

The controller has three states:
- `ST_IDLE`: waiting for a tick. Tick with a nonzero count goes to `ST_SCAN`. Tick with differing pointers and a zero count goes to `ST_FAULT`. Any other tick stays in `ST_IDLE`.
- `ST_SCAN`: visits one slot per cycle. After the last slot counted at the start of the pass, it returns to `ST_IDLE`.
- `ST_FAULT`: absorbing until reset.

Top module: `deferred_update_queue`

## Requirements
- R1: After reset `enq_ready`=1, `busy`=0, `wr_valid`=0 and `ring_fault`=0.
- R2: The ring holds SLOTS entries (default 4). While it holds SLOTS entries, `enq_ready`=0 and a posted `enq_valid` is dropped; that entry is never written.
- R3: A tick in `ST_IDLE` with a nonzero count raises `busy` at the next edge. The pass visits exactly the entries live at its start, one per cycle, oldest first. A tick during a pass is ignored. An entry posted during a pass is first visited by the next pass.
- R4: Each visit lowers the entry's delay by one, and the entry expires when the delay reaches zero. A posted delay of 0 acts as 1. The write for a slot visited at edge k is shown after edge k, and the first visit is at the second edge after the tick is sampled.
- R5: Bit mode (`enq_bit_mode`=1): `wr_mask` is one-hot at `enq_bit_pos` (taken modulo 32 when `enq_wide`=0). `wr_data` equals `wr_mask` when the value is nonzero and is 0 when the value is zero.
- R6: Word mode: with `enq_wide`=0, `wr_mask`=0x00000000FFFFFFFF and `wr_data` is the low 32 value bits. With `enq_wide`=1, `wr_mask` is all ones and `wr_data` is the value.
- R7: Entries that expire in the same pass are issued in ring order, one per cycle, with `wr_valid` high for each.
- R8: Only the head slot is reclaimed. An expired non-head entry keeps its slot, so `enq_ready` stays 0 on a full ring, and it is never issued again. It is freed in the pass where every older entry has been freed.
- R9: `ring_fault` rises when a tick finds the pointers differing with a zero count. It is sticky until reset and blocks posting and passes. It stays 0 under legal traffic.
- R10: A tick on an empty ring issues no write and leaves `busy` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_valid | input | 1 | Post an entry this cycle |
| enq_ready | output | 1 | Ring can accept an entry |
| enq_dest | input | 5 | Destination index |
| enq_bit_mode | input | 1 | 1: single-bit update, 0: word write |
| enq_bit_pos | input | 6 | Bit position for bit mode |
| enq_value | input | 64 | Value (bit mode: zero/nonzero) |
| enq_wide | input | 1 | 1: 64-bit size, 0: 32-bit size |
| enq_delay | input | 4 | Ticks until the update applies |
| tick | input | 1 | Start a drain pass |
| busy | output | 1 | A pass is running |
| wr_valid | output | 1 | Write-port update valid |
| wr_dest | output | 5 | Write-port destination |
| wr_mask | output | 64 | Bits to modify |
| wr_data | output | 64 | New values of the masked bits |
| ring_fault | output | 1 | Sticky pointer/count mismatch |

## Verification
A wrong delay count or a bad head pointer shows up on the write port within the pass after the fault. It appears as a write that is missing, early or repeated, or as writes out of ring order. A lost or extra free shows in `enq_ready` on a filled ring at the end of that same pass. Mask and data errors are visible in the cycle right after the slot's visit. A pass that stops or runs long shows in when `busy` falls.

// File: rtl/dq_pkg.sv
package dq_pkg;
    localparam int DEST_W  = 5;
    localparam int BIT_W   = 6;
    localparam int DATA_W  = 64;
    localparam int HALF_W  = DATA_W / 2;
    localparam int DELAY_W = 4;

    typedef struct packed {
        logic               valid;
        logic               done;
        logic [DEST_W-1:0]  dest;
        logic               bit_mode;
        logic [BIT_W-1:0]   bit_pos;
        logic [DATA_W-1:0]  value;
        logic               wide;
        logic [DELAY_W-1:0] delay;
    } slot_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SCAN  = 2'd1,
        ST_FAULT = 2'd2
    } dq_state_t;
endpackage

// File: rtl/dq_slot_store.sv
module dq_slot_store
    import dq_pkg::*;
#(
    parameter int SLOTS = 4,
    parameter int PTR_W = $clog2(SLOTS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enq_en,
    input  logic [PTR_W-1:0] enq_idx,
    input  slot_t            enq_entry,
    input  logic             upd_en,
    input  logic [PTR_W-1:0] upd_idx,
    input  slot_t            upd_entry,
    input  logic [PTR_W-1:0] rd_idx,
    output slot_t            rd_entry
);
    slot_t slots [SLOTS];

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)
                slots[i] <= '0;
            else if (enq_en && enq_idx == PTR_W'(i))
                slots[i] <= enq_entry;
            else if (upd_en && upd_idx == PTR_W'(i))
                slots[i] <= upd_entry;
        end
    end

    assign rd_entry = slots[rd_idx];

    // R3: a post during a pass never lands in a slot being visited
    assert_no_slot_collision_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(enq_en && upd_en && enq_idx == upd_idx));
endmodule

// File: rtl/dq_write_fmt.sv
module dq_write_fmt
    import dq_pkg::*;
(
    input  logic              bit_mode,
    input  logic [BIT_W-1:0]  bit_pos,
    input  logic [DATA_W-1:0] value,
    input  logic              wide,
    output logic [DATA_W-1:0] mask,
    output logic [DATA_W-1:0] data
);
    logic [BIT_W-1:0] eff_pos;

    always_comb begin
        eff_pos = wide ? bit_pos : {1'b0, bit_pos[BIT_W-2:0]};
        if (bit_mode) begin
            mask = {{(DATA_W-1){1'b0}}, 1'b1} << eff_pos;
            data = (value != '0) ? mask : '0;
        end else begin
            mask = wide ? {DATA_W{1'b1}} : {{HALF_W{1'b0}}, {HALF_W{1'b1}}};
            data = value & mask;
        end
    end
endmodule

// File: rtl/deferred_update_queue.sv
module deferred_update_queue
    import dq_pkg::*;
#(
    parameter int SLOTS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enq_valid,
    output logic              enq_ready,
    input  logic [DEST_W-1:0] enq_dest,
    input  logic              enq_bit_mode,
    input  logic [BIT_W-1:0]  enq_bit_pos,
    input  logic [DATA_W-1:0] enq_value,
    input  logic              enq_wide,
    input  logic [DELAY_W-1:0] enq_delay,
    input  logic              tick,
    output logic              busy,
    output logic              wr_valid,
    output logic [DEST_W-1:0] wr_dest,
    output logic [DATA_W-1:0] wr_mask,
    output logic [DATA_W-1:0] wr_data,
    output logic              ring_fault
);
    localparam int PTR_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
    localparam int CNT_W = $clog2(SLOTS + 1);

    dq_state_t state, state_nxt;
    logic [PTR_W-1:0] in_ptr, out_ptr, scan_idx;
    logic [CNT_W-1:0] total, scan_left;

    slot_t cur, upd_entry, enq_entry;
    logic  visiting, expire_now, free_now, upd_en, enq_fire, start_scan;
    logic [DATA_W-1:0] fmt_mask, fmt_data;

    function automatic logic [PTR_W-1:0] ring_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(SLOTS - 1)) ? '0 : p + 1'b1;
    endfunction

    assign enq_ready  = (total != CNT_W'(SLOTS)) && (state != ST_FAULT);
    assign enq_fire   = enq_valid && enq_ready;
    assign busy       = (state == ST_SCAN);
    assign ring_fault = (state == ST_FAULT);
    assign visiting   = (state == ST_SCAN);
    assign start_scan = (state == ST_IDLE) && tick && (total != '0);

    always_comb begin
        enq_entry          = '0;
        enq_entry.valid    = 1'b1;
        enq_entry.dest     = enq_dest;
        enq_entry.bit_mode = enq_bit_mode;
        enq_entry.bit_pos  = enq_bit_pos;
        enq_entry.value    = enq_value;
        enq_entry.wide     = enq_wide;
        enq_entry.delay    = (enq_delay == '0) ? DELAY_W'(1) : enq_delay;
    end

    dq_slot_store #(.SLOTS(SLOTS), .PTR_W(PTR_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .enq_en    (enq_fire),
        .enq_idx   (in_ptr),
        .enq_entry (enq_entry),
        .upd_en    (upd_en),
        .upd_idx   (scan_idx),
        .upd_entry (upd_entry),
        .rd_idx    (scan_idx),
        .rd_entry  (cur)
    );

    dq_write_fmt u_fmt (
        .bit_mode (cur.bit_mode),
        .bit_pos  (cur.bit_pos),
        .value    (cur.value),
        .wide     (cur.wide),
        .mask     (fmt_mask),
        .data     (fmt_data)
    );

    // Per-visit slot update
    always_comb begin
        expire_now = cur.valid && !cur.done && (cur.delay <= DELAY_W'(1));
        free_now   = visiting && cur.valid && (cur.done || expire_now)
                     && (scan_idx == out_ptr);
        upd_en     = visiting && cur.valid;
        upd_entry  = cur;
        if (free_now) begin
            upd_entry = '0;
        end else if (expire_now) begin
            upd_entry.done  = 1'b1;
            upd_entry.delay = '0;
        end else if (!cur.done) begin
            upd_entry.delay = cur.delay - 1'b1;
        end
    end

    // Next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (tick && (in_ptr != out_ptr) && (total == '0))
                    state_nxt = ST_FAULT;
                else if (start_scan)
                    state_nxt = ST_SCAN;
            end
            ST_SCAN: begin
                if (scan_left == CNT_W'(1))
                    state_nxt = ST_IDLE;
            end
            ST_FAULT: state_nxt = ST_FAULT;
            default:  state_nxt = ST_FAULT;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // Ring bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_ptr    <= '0;
            out_ptr   <= '0;
            total     <= '0;
            scan_idx  <= '0;
            scan_left <= '0;
        end else begin
            if (enq_fire)
                in_ptr <= ring_inc(in_ptr);
            if (free_now)
                out_ptr <= ring_inc(out_ptr);
            total <= total + CNT_W'(enq_fire) - CNT_W'(free_now);
            if (start_scan) begin
                scan_idx  <= out_ptr;
                scan_left <= total;
            end else if (visiting) begin
                scan_idx  <= ring_inc(scan_idx);
                scan_left <= scan_left - 1'b1;
            end
        end
    end

    // Write port outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_valid <= 1'b0;
            wr_dest  <= '0;
            wr_mask  <= '0;
            wr_data  <= '0;
        end else begin
            wr_valid <= visiting && expire_now;
            if (visiting && expire_now) begin
                wr_dest <= cur.dest;
                wr_mask <= fmt_mask;
                wr_data <= fmt_data;
            end
        end
    end

    assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        total <= CNT_W'(SLOTS));

    assert_full_drops_post_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_SCAN && enq_valid && !enq_ready) |=> (total == $past(total)));

    assert_write_follows_visit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> $past(state == ST_SCAN));

    assert_fault_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ring_fault |=> ring_fault);

    assert_empty_ring_aligned_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && total == '0) |-> (in_ptr == out_ptr));
endmodule

// File: tb/tb_deferred_update_queue.sv
module tb_deferred_update_queue;
    import dq_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enq_valid = 1'b0;
    logic enq_ready;
    logic [DEST_W-1:0] enq_dest = '0;
    logic enq_bit_mode = 1'b0;
    logic [BIT_W-1:0] enq_bit_pos = '0;
    logic [DATA_W-1:0] enq_value = '0;
    logic enq_wide = 1'b0;
    logic [DELAY_W-1:0] enq_delay = '0;
    logic tick = 1'b0;
    logic busy, wr_valid, ring_fault;
    logic [DEST_W-1:0] wr_dest;
    logic [DATA_W-1:0] wr_mask, wr_data;

    always #5 clk = ~clk;

    deferred_update_queue #(.SLOTS(4)) dut (
        .clk(clk), .rst_n(rst_n),
        .enq_valid(enq_valid), .enq_ready(enq_ready),
        .enq_dest(enq_dest), .enq_bit_mode(enq_bit_mode),
        .enq_bit_pos(enq_bit_pos), .enq_value(enq_value),
        .enq_wide(enq_wide), .enq_delay(enq_delay),
        .tick(tick), .busy(busy),
        .wr_valid(wr_valid), .wr_dest(wr_dest),
        .wr_mask(wr_mask), .wr_data(wr_data),
        .ring_fault(ring_fault)
    );

    int n_checks = 0;
    int n_fail = 0;

    typedef struct packed {
        logic [4:0]  dest;
        logic        bmode;
        logic [5:0]  bpos;
        logic [63:0] value;
        logic        wide;
        logic [3:0]  delay;
    } enq_row_t;

    typedef struct packed {
        logic [1:0]  pass;
        logic [4:0]  dest;
        logic [63:0] mask;
        logic [63:0] data;
    } exp_row_t;

    localparam enq_row_t ENQ_TAB [4] = '{
        '{5'd3, 1'b1, 6'd5,  64'h1,                   1'b0, 4'd2},
        '{5'd7, 1'b0, 6'd0,  64'hDEAD_BEEF_1234_5678, 1'b0, 4'd1},
        '{5'd1, 1'b1, 6'd63, 64'h0,                   1'b1, 4'd1},
        '{5'd9, 1'b0, 6'd0,  64'h0123_4567_89AB_CDEF, 1'b1, 4'd3}
    };

    localparam exp_row_t EXP_TAB [4] = '{
        '{2'd1, 5'd7, 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_1234_5678},
        '{2'd1, 5'd1, 64'h8000_0000_0000_0000, 64'h0},
        '{2'd2, 5'd3, 64'h20,                  64'h20},
        '{2'd3, 5'd9, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0123_4567_89AB_CDEF}
    };

    logic [DEST_W-1:0] log_dest [16];
    logic [DATA_W-1:0] log_mask [16];
    logic [DATA_W-1:0] log_data [16];
    int log_n = 0;

    always @(negedge clk) begin
        if (rst_n && wr_valid && log_n < 16) begin
            log_dest[log_n] = wr_dest;
            log_mask[log_n] = wr_mask;
            log_data[log_n] = wr_data;
            log_n = log_n + 1;
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic post(input enq_row_t r);
        @(negedge clk);
        enq_valid    = 1'b1;
        enq_dest     = r.dest;
        enq_bit_mode = r.bmode;
        enq_bit_pos  = r.bpos;
        enq_value    = r.value;
        enq_wide     = r.wide;
        enq_delay    = r.delay;
        @(negedge clk);
        enq_valid = 1'b0;
    endtask

    task automatic run_pass();
        log_n = 0;
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        for (int i = 0; i < 50 && busy; i++) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 64'h0, 64'h1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 enq_ready", {63'h0, enq_ready}, 64'h1);
        check("R1 busy", {63'h0, busy}, 64'h0);
        check("R1 wr_valid", {63'h0, wr_valid}, 64'h0);
        check("R1 ring_fault", {63'h0, ring_fault}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 tick on empty ring
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        check("R10 busy stays low", {63'h0, busy}, 64'h0);
        @(negedge clk);
        check("R10 no write", {63'h0, wr_valid}, 64'h0);

        // Table scenario: R2 R5 R6 R7 R8
        for (int i = 0; i < 4; i++) post(ENQ_TAB[i]);
        check("R2 full blocks", {63'h0, enq_ready}, 64'h0);
        post('{5'd15, 1'b0, 6'd0, 64'hFFFF, 1'b1, 4'd1});
        for (int p = 1; p <= 3; p++) begin
            int k;
            run_pass();
            k = 0;
            for (int e = 0; e < 4; e++) begin
                if (int'(EXP_TAB[e].pass) == p) begin
                    check("R7 dest order", {59'h0, log_dest[k]}, {59'h0, EXP_TAB[e].dest});
                    check("R5/R6 mask", log_mask[k], EXP_TAB[e].mask);
                    check("R5/R6 data", log_data[k], EXP_TAB[e].data);
                    k++;
                end
            end
            check("R8 write count per pass (R2 dropped post absent)", 64'(log_n), 64'(k));
            if (p == 1) check("R8 non-head expiry keeps slot", {63'h0, enq_ready}, 64'h0);
            if (p == 2) check("R8 head frees finished slots", {63'h0, enq_ready}, 64'h1);
        end
        run_pass();
        check("R2 dropped post never written", 64'(log_n), 64'h0);

        // R4 exact timing, delay 0 as 1, R5 narrow bit modulo 32
        post('{5'd12, 1'b1, 6'd37, 64'h5, 1'b0, 4'd0});
        log_n = 0;
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        check("R3 busy after tick", {63'h0, busy}, 64'h1);
        check("R4 no write before visit", {63'h0, wr_valid}, 64'h0);
        @(negedge clk);
        check("R4 write after visit", {63'h0, wr_valid}, 64'h1);
        check("R4 dest", {59'h0, wr_dest}, 64'd12);
        check("R5 narrow bit mask", wr_mask, 64'h20);
        check("R5 set data", wr_data, 64'h20);
        @(negedge clk);
        check("R4 single write", {63'h0, wr_valid}, 64'h0);

        // R3 tick ignored during pass, post during pass deferred
        post('{5'd20, 1'b0, 6'd0, 64'hAAAA_0000_BBBB_1111, 1'b1, 4'd1});
        post('{5'd21, 1'b0, 6'd0, 64'hCCCC_0000_DDDD_2222, 1'b0, 4'd1});
        log_n = 0;
        @(negedge clk); tick = 1'b1;
        @(negedge clk);
        enq_valid = 1'b1; enq_dest = 5'd22; enq_bit_mode = 1'b1;
        enq_bit_pos = 6'd0; enq_value = 64'h0; enq_wide = 1'b1; enq_delay = 4'd1;
        @(negedge clk);
        tick = 1'b0; enq_valid = 1'b0;
        for (int i = 0; i < 50 && busy; i++) @(negedge clk);
        @(negedge clk);
        check("R3 pass covers start set only", 64'(log_n), 64'd2);
        check("R3 first visited oldest", {59'h0, log_dest[0]}, 64'd20);
        check("R3 second visited", {59'h0, log_dest[1]}, 64'd21);
        check("R6 narrow word data", log_data[1], 64'h0000_0000_DDDD_2222);
        check("R6 wide word data", log_data[0], 64'hAAAA_0000_BBBB_1111);
        run_pass();
        check("R3 deferred post in next pass", 64'(log_n), 64'd1);
        check("R5 clear mask", log_mask[0], 64'h1);
        check("R5 clear data", log_data[0], 64'h0);
        check("R9 no fault under legal traffic", {63'h0, ring_fault}, 64'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule